// File: doc/BRIEF.md
# Strobe-Ordered DRAM Cycle Responder

This block is the memory side of an asynchronous multiplexed-address DRAM, rebuilt as synchronous logic. A fast clock samples the row strobe, column strobe, write strobe and output-enable strobe (all active low) with the shared address bus. The block does not receive a command code. It works out what each row-strobe period was from the order in which the strobe edges arrive. It then serves reads and writes against a small word array. Row and column widths are parameters.

The block supports single and fast-page accesses, early writes, output-enable-controlled writes, read-modify-write, refresh with an externally supplied row, refresh with an internal row counter, and hidden refresh. The data output enable is raised only while the strobes permit it. Each time the row strobe rises, a one-cycle status pulse reports the decoded cycle type and the row it used. A controller testbench can use this pulse to confirm that its own sequencing was understood.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, dq_oe and stat_valid are 0 and refresh_row is 0.
- R2: Row and column latching and read output.
  - The row address is latched when ras_n falls while cas_n is high.
  - The column address is latched at each cas_n fall while ras_n is low.
  - dq_out then carries the word at {row, column}.
  - dq_oe is 1 while cas_n and oe_n are low and we_n is high.
  - The period reports type code 0 (read).
- R3: Early write.
  - If we_n is low when cas_n falls, dq_in is written at that edge.
  - dq_oe stays 0 for the rest of that column access.
  - The period reports code 1.
- R4: Output-enable-controlled write.
  - This applies when we_n falls during a column access in which no data has yet been driven.
  - dq_in is written at the we_n fall.
  - The period reports code 2.
- R5: Read-modify-write.
  - This applies when we_n falls after the old word has been driven for at least one clock.
  - dq_in is written at the we_n fall.
  - Afterwards the new word is what gets read.
  - The period reports code 3.
- R6: While ras_n stays low, every new cas_n fall accesses a new column of the same row (fast page).
- R7: A ras_n low period with no cas_n fall reports code 4, and stat_row equals the latched row. The array is not changed.
- R8: Counter refresh.
  - If cas_n is already low when ras_n falls and no column access is open, the period reports code 5 and ignores the address.
  - stat_row is the internal counter value.
  - The counter then advances by one and wraps at the row count.
  - refresh_row changes only at a status pulse.
- R9: Hidden refresh.
  - If cas_n is held low from a column access across a ras_n rise and a new ras_n fall, the new period reports code 6 and uses the counter as in R8.
  - The earlier read word stays on dq_out with dq_oe 1 throughout.
- R10: dq_oe drops in the same cycle that cas_n or oe_n goes high. dq_oe is never 1 without an open column access, including during a counter refresh.
- R11: stat_valid rises exactly one clock after ras_n is sampled high following a low sample, and it lasts one clock.
  - In a fast-page period, the reported type uses this priority: read-modify-write, then late write, then early write, then read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DATA_W | Write data from controller |
| dq_out | output | DATA_W | Read data toward controller |
| dq_oe | output | 1 | Drive enable for dq_out |
| stat_valid | output | 1 | One-cycle pulse at end of a row period |
| stat_type | output | 3 | Decoded cycle code (0..6) |
| stat_row | output | ROW_BITS | Row used by the finished period |
| refresh_row | output | ROW_BITS | Internal refresh counter value |

## Verification
Every word of the array is first filled by fast-page early writes and then read back by fast-page reads, so that address decoding is shown to be correct across all rows and columns. Selected words are then rewritten in three ways: with a write strobe present at the column edge, with a write strobe arriving before any data was driven, and with a write strobe arriving after the old word was driven. The three cases must produce the distinct codes 1, 2 and 3, and each must store the new word. Counter refresh is repeated past the row count to expose the wrap. A hidden refresh follows a read to check that the data remains on the pins. A row-only refresh is checked against a final full read sweep, which confirms it changed nothing.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;

  typedef enum logic [2:0] {
    CYC_READ   = 3'd0,
    CYC_EWR    = 3'd1,
    CYC_LWR    = 3'd2,
    CYC_RMW    = 3'd3,
    CYC_RONLY  = 3'd4,
    CYC_CBR    = 3'd5,
    CYC_HIDDEN = 3'd6
  } cyc_e;

  // Pick the reported type of a finished row period from its event flags.
  function automatic cyc_e classify(input logic cbr, input logic hid,
                                    input logic had_col, input logic rmw,
                                    input logic lwr, input logic ewr);
    if (hid)           return CYC_HIDDEN;
    else if (cbr)      return CYC_CBR;
    else if (!had_col) return CYC_RONLY;
    else if (rmw)      return CYC_RMW;
    else if (lwr)      return CYC_LWR;
    else if (ewr)      return CYC_EWR;
    else               return CYC_READ;
  endfunction

  // Increment with wrap at a limit.
  function automatic logic [15:0] wrap_inc(input logic [15:0] v, input logic [15:0] lim);
    return (v + 16'd1 >= lim) ? 16'd0 : v + 16'd1;
  endfunction

endpackage

// File: rtl/strobe_delay.sv
module strobe_delay #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] prev
);
  // Strobes are active low, so the idle value is all ones.
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev[i] <= 1'b1;
      else        prev[i] <= sig[i];
    end
  end
endmodule

// File: rtl/refresh_ctr.sv
module refresh_ctr #(
  parameter int ROW_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  output logic [ROW_BITS-1:0] cnt
);
  import dram_dec_pkg::*;
  localparam int ROWS = 1 << ROW_BITS;

  logic [15:0] nxt;
  assign nxt = wrap_inc(16'(cnt), 16'(ROWS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (adv) cnt <= nxt[ROW_BITS-1:0];
  end
endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int AB = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AB-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AB-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AB;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end
  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   dq_in,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe,
  output logic                stat_valid,
  output logic [2:0]          stat_type,
  output logic [ROW_BITS-1:0] stat_row,
  output logic [ROW_BITS-1:0] refresh_row
);
  import dram_dec_pkg::*;
  localparam int WA = ROW_BITS + COL_BITS;

  // Previous sampled strobes: bit0 row, bit1 column, bit2 write.
  logic [2:0] prev;
  strobe_delay #(.N(3)) u_dly (
    .clk(clk), .rst_n(rst_n), .sig({we_n, cas_n, ras_n}), .prev(prev)
  );

  // Named edge events.
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  assign ras_fall = prev[0] & ~ras_n;
  assign ras_rise = ~prev[0] & ras_n;
  assign cas_fall = prev[1] & ~cas_n;
  assign cas_rise = ~prev[1] & cas_n;
  assign we_fall  = prev[2] & ~we_n;

  // Period and access state.
  logic in_per, refr_per, hid_per, cbr_per;
  logic had_col, p_ewr, p_lwr, p_rmw;
  logic col_valid, acc_early, drove;
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_q;

  // Qualified events used by the datapath and the checker.
  logic col_go, late_go, refr_done;
  assign col_go    = cas_fall & in_per & ~ras_n & ~refr_per;
  assign late_go   = we_fall & col_valid & ~cas_n & ~acc_early & in_per & ~refr_per;
  assign refr_done = ras_rise & refr_per;

  logic          wr_en;
  logic [WA-1:0] wr_addr, rd_addr;
  assign wr_en   = (col_go & ~we_n) | late_go;
  assign wr_addr = late_go ? {row_q, col_q} : {row_q, addr[COL_BITS-1:0]};
  assign rd_addr = {row_q, col_q};

  word_store #(.AB(WA), .DW(DATA_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(dq_in),
    .rd_addr(rd_addr), .rd_data(dq_out)
  );

  refresh_ctr #(.ROW_BITS(ROW_BITS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .adv(refr_done), .cnt(refresh_row)
  );

  assign dq_oe = col_valid & ~cas_n & ~oe_n & we_n & ~acc_early;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_per <= 1'b0; refr_per <= 1'b0; hid_per <= 1'b0; cbr_per <= 1'b0;
      had_col <= 1'b0; p_ewr <= 1'b0; p_lwr <= 1'b0; p_rmw <= 1'b0;
      col_valid <= 1'b0; acc_early <= 1'b0; drove <= 1'b0;
      row_q <= '0; col_q <= '0;
      stat_valid <= 1'b0; stat_type <= 3'd0; stat_row <= '0;
    end else begin
      stat_valid <= 1'b0;
      if (dq_oe) drove <= 1'b1;

      if (ras_fall) begin
        in_per  <= 1'b1;
        had_col <= 1'b0; p_ewr <= 1'b0; p_lwr <= 1'b0; p_rmw <= 1'b0;
        if (!cas_n) begin
          refr_per <= 1'b1;
          hid_per  <= col_valid;
          cbr_per  <= ~col_valid;
        end else begin
          row_q    <= addr[ROW_BITS-1:0];
          refr_per <= 1'b0; hid_per <= 1'b0; cbr_per <= 1'b0;
        end
      end

      if (ras_rise) begin
        in_per     <= 1'b0;
        refr_per   <= 1'b0;
        stat_valid <= 1'b1;
        stat_type  <= classify(cbr_per, hid_per, had_col, p_rmw, p_lwr, p_ewr);
        stat_row   <= refr_per ? refresh_row : row_q;
      end

      if (col_go) begin
        col_q     <= addr[COL_BITS-1:0];
        col_valid <= 1'b1;
        had_col   <= 1'b1;
        acc_early <= ~we_n;
        drove     <= 1'b0;
        if (!we_n) p_ewr <= 1'b1;
      end

      if (cas_rise) begin
        col_valid <= 1'b0;
        acc_early <= 1'b0;
        drove     <= 1'b0;
      end

      if (late_go) begin
        if (drove) p_rmw <= 1'b1;
        else       p_lwr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_cycle_decoder_chk.sv
module dram_cycle_decoder_chk #(
  parameter int ROW_BITS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ras_n,
  input logic                cas_n,
  input logic                we_n,
  input logic                oe_n,
  input logic                dq_oe,
  input logic                stat_valid,
  input logic [2:0]          stat_type,
  input logic [ROW_BITS-1:0] stat_row,
  input logic [ROW_BITS-1:0] refresh_row
);
  import dram_dec_pkg::*;
  localparam int ROWS = 1 << ROW_BITS;

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!cas_n && !oe_n && we_n));

  // R11
  stat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);

  // R11
  stat_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> stat_valid);

  // R8
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && (stat_type == CYC_CBR || stat_type == CYC_HIDDEN)) |->
      (refresh_row == ROW_BITS'(({1'b0, stat_row} + 1) % ROWS)));

  // R8
  ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_valid |-> $stable(refresh_row));

  // R11
  type_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_type <= 3'd6));
endmodule

bind dram_cycle_decoder dram_cycle_decoder_chk #(.ROW_BITS(ROW_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .oe_n(oe_n), .dq_oe(dq_oe), .stat_valid(stat_valid), .stat_type(stat_type),
  .stat_row(stat_row), .refresh_row(refresh_row)
);

// File: tb/tb_dram_cycle_decoder.sv
module tb_dram_cycle_decoder;
  localparam int RB = 3, CB = 3, DW = 8;
  localparam int ROWS = 1 << RB, COLS = 1 << CB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [2:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe, stat_valid;
  logic [2:0] stat_type;
  logic [RB-1:0] stat_row, refresh_row;

  int total = 0, bad = 0, ctr = 0;
  logic [DW-1:0] model [ROWS*COLS];

  always #4 clk = ~clk;

  dram_cycle_decoder #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .stat_valid(stat_valid), .stat_type(stat_type), .stat_row(stat_row),
    .refresh_row(refresh_row)
  );

  function automatic logic [DW-1:0] pat(input int r, input int c, input int s);
    return DW'((r * 37 + c * 11 + s * 101 + 5) ^ 8'h5A);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic row_open(input int r);
    addr = 3'(r); ras_n = 1'b0; @(negedge clk);
  endtask

  task automatic col_open(input int c, input logic w, input logic o);
    addr = 3'(c); we_n = w; oe_n = o; cas_n = 1'b0; @(negedge clk);
  endtask

  task automatic col_close();
    cas_n = 1'b1; @(negedge clk);
  endtask

  task automatic row_close(input string tag, input int code, input int row);
    ras_n = 1'b1; @(negedge clk);
    chk({tag, " R11 valid"}, 32'(stat_valid), 1);
    chk({tag, " type"}, 32'(stat_type), 32'(code));
    chk({tag, " row"}, 32'(stat_row), 32'(row));
    @(negedge clk);
    chk({tag, " R11 one-cycle"}, 32'(stat_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 dq_oe", 32'(dq_oe), 0);
    chk("R1 stat_valid", 32'(stat_valid), 0);
    chk("R1 refresh_row", 32'(refresh_row), 0);

    // R3 R6: fill every word with fast-page early writes
    for (int r = 0; r < ROWS; r++) begin
      row_open(r);
      for (int c = 0; c < COLS; c++) begin
        dq_in = pat(r, c, 0);
        model[r*COLS+c] = dq_in;
        col_open(c, 1'b0, 1'b0);
        chk("R3 early write hi-z", 32'(dq_oe), 0);
        col_close();
      end
      we_n = 1'b1;
      row_close("R3", 1, r);
    end

    // R2 R6 R10: fast-page read of every word
    for (int r = 0; r < ROWS; r++) begin
      row_open(r);
      for (int c = 0; c < COLS; c++) begin
        col_open(c, 1'b1, 1'b0);
        chk("R2 oe", 32'(dq_oe), 1);
        chk("R6 data", 32'(dq_out), 32'(model[r*COLS+c]));
        col_close();
        chk("R10 off after cas rise", 32'(dq_oe), 0);
      end
      row_close("R2", 0, r);
    end

    // R10: output enable strobe gates the drive
    row_open(2);
    col_open(5, 1'b1, 1'b1);
    chk("R10 oe_n high", 32'(dq_oe), 0);
    oe_n = 1'b0; @(negedge clk);
    chk("R10 oe_n low", 32'(dq_oe), 1);
    oe_n = 1'b1; @(negedge clk);
    chk("R10 oe_n back high", 32'(dq_oe), 0);
    col_close();
    row_close("R2 gated", 0, 2);

    // R4: output-enable-controlled write on a few words
    for (int k = 0; k < 4; k++) begin
      automatic int r = (k * 3 + 1) % ROWS;
      automatic int c = (k * 5 + 2) % COLS;
      row_open(r);
      col_open(c, 1'b1, 1'b1);
      chk("R4 no drive", 32'(dq_oe), 0);
      dq_in = pat(r, c, 1);
      model[r*COLS+c] = dq_in;
      we_n = 1'b0; @(negedge clk);
      we_n = 1'b1; @(negedge clk);
      col_close();
      row_close("R4", 2, r);
    end

    // R5: read-modify-write
    for (int k = 0; k < 4; k++) begin
      automatic int r = (k * 5 + 6) % ROWS;
      automatic int c = (k * 3 + 7) % COLS;
      row_open(r);
      col_open(c, 1'b1, 1'b0);
      chk("R5 old data", 32'(dq_out), 32'(model[r*COLS+c]));
      @(negedge clk);
      dq_in = pat(r, c, 2);
      model[r*COLS+c] = dq_in;
      we_n = 1'b0; @(negedge clk);
      chk("R5 drive off during write", 32'(dq_oe), 0);
      we_n = 1'b1; @(negedge clk);
      chk("R5 new data", 32'(dq_out), 32'(model[r*COLS+c]));
      col_close();
      row_close("R5", 3, r);
    end

    // R11: mixed fast page reports highest-priority type (late over early/read)
    row_open(4);
    dq_in = pat(4, 0, 3); model[4*COLS+0] = dq_in;
    col_open(0, 1'b0, 1'b1); col_close();
    we_n = 1'b1;
    col_open(1, 1'b1, 1'b1);
    dq_in = pat(4, 1, 3); model[4*COLS+1] = dq_in;
    we_n = 1'b0; @(negedge clk); we_n = 1'b1; @(negedge clk);
    col_close();
    col_open(2, 1'b1, 1'b0); col_close();
    row_close("R11 priority", 2, 4);

    // R7: row-only refresh
    row_open(6);
    row_close("R7", 4, 6);

    // R8: counter refresh, run past the wrap
    for (int k = 0; k < ROWS + 3; k++) begin
      oe_n = 1'b0; cas_n = 1'b0; @(negedge clk);
      chk("R10 cas without row", 32'(dq_oe), 0);
      addr = 3'(k * 7); ras_n = 1'b0; @(negedge clk);
      chk("R10 refresh no drive", 32'(dq_oe), 0);
      row_close("R8", 5, ctr);
      col_close();
      ctr = (ctr + 1) % ROWS;
      chk("R8 counter", 32'(refresh_row), 32'(ctr));
    end

    // R9: hidden refresh keeps read data on the pins
    for (int k = 0; k < 2; k++) begin
      automatic int r = 3 + k, c = 6 - k;
      row_open(r);
      col_open(c, 1'b1, 1'b0);
      chk("R9 read before", 32'(dq_out), 32'(model[r*COLS+c]));
      row_close("R9 read part", 0, r);
      addr = 3'(k + 1); ras_n = 1'b0; @(negedge clk);
      chk("R9 held oe", 32'(dq_oe), 1);
      chk("R9 held data", 32'(dq_out), 32'(model[r*COLS+c]));
      row_close("R9", 6, ctr);
      ctr = (ctr + 1) % ROWS;
      chk("R9 counter", 32'(refresh_row), 32'(ctr));
      col_close();
      chk("R9 released", 32'(dq_oe), 0);
    end

    // R7 R2: final full sweep confirms contents
    for (int r = 0; r < ROWS; r++) begin
      row_open(r);
      for (int c = 0; c < COLS; c++) begin
        col_open(c, 1'b1, 1'b0);
        chk("R7 final sweep", 32'(dq_out), 32'(model[r*COLS+c]));
        col_close();
      end
      row_close("R2 sweep", 0, r);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule